// File: doc/BRIEF.md
# Prioritized Exception Dispatch Unit

This unit decides which pending exception a processor core services next, and it computes the state change that servicing causes. Each evaluation takes four inputs: a vector of pending-exception flags, the address of the current instruction, the address of the next instruction and the machine state word. In the following cycle the unit reports the outcome. If an exception is taken, it gives the handler entry address, the saved return address, the saved state word, the new machine state and the pending vector with the serviced flag removed.

Faults raised by instructions form a synchronous tier, and this tier always wins. Interrupt-style events form an asynchronous tier. The unit considers that tier only when no synchronous flag is pending and the machine state allows external events. A debug memory-check flag is a special synchronous case: it discards a pending data-storage fault and takes no vector. The core's pipeline instantiates the unit beside its architectural state. It writes the results back when the completion pulse appears.

Top module: `exc_dispatch`

## Requirements
- R1: Synchronous flags are served in this priority order, highest first, with these pending bit positions and entry addresses:
  - bit 0, instruction-storage fault, 0x400
  - bit 1, program, 0x700
  - bit 2, system call, 0xC00
  - bit 3, FPU unavailable, 0x800
  - bit 5, data-storage fault, 0x300
  - bit 6, alignment, 0x600

  When an exception is taken, `vec_o` carries the entry address. The program counter and the next program counter are both loaded from this address.
- R2: The saved return address `srr0_o` takes one of two values. It is `npc_i` for an instruction-storage fault, a system call and every asynchronous exception. It is `pc_i` for program, FPU-unavailable, data-storage and alignment exceptions.
- R3: The saved state `srr1_o` is `msr_i & 0x87C0FFFF`. For an instruction-storage fault, bit 30 is also set. For a program exception, the masked bits are ORed into the prior value `srr1_i`.
- R4: On every taken exception, the new state `msr_o` is formed in two steps. First, bit 0 is loaded from bit 16 of `msr_i`. Then the bits in 0x04EF36 are cleared.
- R5: The memory-check flag sits at bit 4, between FPU unavailable and data-storage in priority. When it wins, it and bit 5 are both cleared, nothing is taken and `msr_o` equals `msr_i`.
- R6: The asynchronous tier is considered only when bits 6..0 are all clear and bit 15 of `msr_i` is set. Its order is external (bit 7, 0x500), then performance monitor (bit 8, 0xF00), then decrementer (bit 9, 0x900).
- R7: `pend_o` equals `pend_i` with only the serviced flag cleared. The memory-check case of R5 is the one exception to this. Nothing is cleared when nothing is served.
- R8: `done_o` pulses for exactly one cycle, one clock after each cycle in which `eval_i` is high. `taken_o` and `err_o` can be high only together with `done_o`.
- R9: `err_o` is raised when the asynchronous tier is considered (R6) and pending bits are set, but none of bits 9..7 is set. In that case nothing is taken.
- R10: During and right after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_i | input | 1 | Evaluate the inputs this cycle |
| pend_i | input | NFLAG (12) | Pending exception flags |
| pc_i | input | XLEN (32) | Address of the current instruction |
| npc_i | input | XLEN (32) | Address of the next instruction |
| msr_i | input | XLEN (32) | Current machine state word |
| srr1_i | input | XLEN (32) | Prior saved-state value (cause bits for program exceptions) |
| done_o | output | 1 | Evaluation result valid |
| taken_o | output | 1 | An exception was dispatched |
| err_o | output | 1 | Unknown asynchronous flag with nothing dispatched |
| vec_o | output | XLEN (32) | Entry address (zero when not taken) |
| srr0_o | output | XLEN (32) | Saved return address |
| srr1_o | output | XLEN (32) | Saved state word |
| msr_o | output | XLEN (32) | Updated machine state word |
| pend_o | output | NFLAG (12) | Pending flags after servicing |

## Verification
The assertions assume two things about the inputs. First, the inputs are stable for the whole evaluation cycle. Second, the state-clear mask includes the external-enable bit, so a taken exception always leaves that bit low.

The stimulus keeps to this by changing the inputs only on the falling edge. It draws pending vectors from four shapes: a single bit, a fully random vector, asynchronous and unknown bits only, and memory-check mixed with data-storage. It also toggles the enable bit randomly, so both tiers and the error path are reached.

// File: rtl/exc_dispatch_pkg.sv
package exc_dispatch_pkg;
   localparam int unsigned F_ISI   = 0;
   localparam int unsigned F_PROG  = 1;
   localparam int unsigned F_SYSC  = 2;
   localparam int unsigned F_FPU   = 3;
   localparam int unsigned F_MCHK  = 4;
   localparam int unsigned F_DSI   = 5;
   localparam int unsigned F_ALIGN = 6;
   localparam int unsigned F_EXT   = 7;
   localparam int unsigned F_PMON  = 8;
   localparam int unsigned F_DEC   = 9;
   localparam int unsigned N_SYNC  = 7;
   localparam int unsigned N_ASYNC = 3;
   localparam int unsigned N_KNOWN = N_SYNC + N_ASYNC;

   typedef logic [N_KNOWN-1:0] kind_vec_t;

   // kinds whose return address is the next instruction
   localparam kind_vec_t RET_NEXT = kind_vec_t'((1 << F_ISI) | (1 << F_SYSC) |
                                                (1 << F_EXT) | (1 << F_PMON) | (1 << F_DEC));

   function automatic logic [31:0] entry_of(input int unsigned kind);
      logic [31:0] a;
      case (kind)
         F_ISI:   a = 32'h0000_0400;
         F_PROG:  a = 32'h0000_0700;
         F_SYSC:  a = 32'h0000_0C00;
         F_FPU:   a = 32'h0000_0800;
         F_DSI:   a = 32'h0000_0300;
         F_ALIGN: a = 32'h0000_0600;
         F_EXT:   a = 32'h0000_0500;
         F_PMON:  a = 32'h0000_0F00;
         F_DEC:   a = 32'h0000_0900;
         default: a = 32'h0;
      endcase
      return a;
   endfunction
endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic         any
);
   if (N < 1) begin : g_bad_n
      $error("exc_prio_pick: N must be at least 1");
   end

   logic [N:0] above;   // above[i]: some request with index below i
   assign above[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_lane
      assign gnt[i]     = req[i] & ~above[i];
      assign above[i+1] = above[i] | req[i];
   end

   assign any = above[N];
endmodule

// File: rtl/exc_ctx_save.sv
module exc_ctx_save
   import exc_dispatch_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter logic [XLEN-1:0] SAVE_MASK = XLEN'(32'h87C0_FFFF),
   parameter logic [XLEN-1:0] CLR_MASK  = XLEN'(32'h0004_EF36),
   parameter int unsigned BIT_LE    = 0,
   parameter int unsigned BIT_ILE   = 16,
   parameter int unsigned BIT_ISTAG = 30
) (
   input  kind_vec_t       sel,
   input  logic            take,
   input  logic [XLEN-1:0] pc_i,
   input  logic [XLEN-1:0] npc_i,
   input  logic [XLEN-1:0] msr_i,
   input  logic [XLEN-1:0] srr1_i,
   output logic [XLEN-1:0] srr0,
   output logic [XLEN-1:0] srr1,
   output logic [XLEN-1:0] msr_new
);
   logic [XLEN-1:0] kept;
   logic [XLEN-1:0] swapped;
   logic            want_next;

   assign kept      = msr_i & SAVE_MASK;
   assign want_next = |(sel & RET_NEXT);

   always_comb begin
      swapped         = msr_i;
      swapped[BIT_LE] = msr_i[BIT_ILE];
   end

   always_comb begin
      srr0    = '0;
      srr1    = '0;
      msr_new = msr_i;
      if (take) begin
         srr0 = want_next ? npc_i : pc_i;
         if (sel[F_PROG])
            srr1 = srr1_i | kept;
         else if (sel[F_ISI]) begin
            srr1            = kept;
            srr1[BIT_ISTAG] = 1'b1;
         end else
            srr1 = kept;
         msr_new = swapped & ~CLR_MASK;
      end
   end
endmodule

// File: rtl/exc_tier_sel.sv
module exc_tier_sel
   import exc_dispatch_pkg::*;
#(
   parameter int unsigned NFLAG = 12
) (
   input  logic [NFLAG-1:0] pend,
   input  logic             ext_en,
   output kind_vec_t        sel,
   output logic             take,
   output logic             err,
   output logic [NFLAG-1:0] pend_next
);
   logic [N_SYNC-1:0]  s_gnt;
   logic [N_ASYNC-1:0] a_gnt;
   logic               s_any, a_any, async_ok, mchk_win;
   kind_vec_t          clr;
   logic [NFLAG-1:0]   clr_full;

   exc_prio_pick #(.N(N_SYNC)) u_sync (
      .req(pend[N_SYNC-1:0]), .gnt(s_gnt), .any(s_any));

   exc_prio_pick #(.N(N_ASYNC)) u_async (
      .req(pend[N_KNOWN-1:N_SYNC]), .gnt(a_gnt), .any(a_any));

   assign async_ok = ~s_any & ext_en;

   always_comb begin
      if (s_any)         sel = {{N_ASYNC{1'b0}}, s_gnt};
      else if (async_ok) sel = {a_gnt, {N_SYNC{1'b0}}};
      else               sel = '0;
   end

   assign mchk_win = sel[F_MCHK];
   assign take     = (|sel) & ~mchk_win;
   assign err      = async_ok & (|pend) & ~a_any;

   always_comb begin
      clr = sel;
      if (mchk_win) clr[F_DSI] = 1'b1;
      clr_full               = '0;
      clr_full[N_KNOWN-1:0]  = clr;
   end

   assign pend_next = pend & ~clr_full;
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
   import exc_dispatch_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned NFLAG     = 12,
   parameter bit          REG_OUT   = 1'b1,
   parameter int unsigned BIT_EE    = 15,
   parameter int unsigned BIT_ILE   = 16,
   parameter int unsigned BIT_LE    = 0,
   parameter int unsigned BIT_ISTAG = 30,
   parameter logic [XLEN-1:0] SAVE_MASK = XLEN'(32'h87C0_FFFF),
   parameter logic [XLEN-1:0] CLR_MASK  = XLEN'(32'h0004_EF36)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eval_i,
   input  logic [NFLAG-1:0] pend_i,
   input  logic [XLEN-1:0]  pc_i,
   input  logic [XLEN-1:0]  npc_i,
   input  logic [XLEN-1:0]  msr_i,
   input  logic [XLEN-1:0]  srr1_i,
   output logic             done_o,
   output logic             taken_o,
   output logic             err_o,
   output logic [XLEN-1:0]  vec_o,
   output logic [XLEN-1:0]  srr0_o,
   output logic [XLEN-1:0]  srr1_o,
   output logic [XLEN-1:0]  msr_o,
   output logic [NFLAG-1:0] pend_o
);
   if (XLEN < 32) begin : g_bad_xlen
      $error("exc_dispatch: XLEN must be at least 32");
   end
   if (NFLAG < N_KNOWN) begin : g_bad_nflag
      $error("exc_dispatch: NFLAG must cover all known kinds");
   end
   if (BIT_EE >= XLEN || BIT_ILE >= XLEN || BIT_LE >= XLEN || BIT_ISTAG >= XLEN) begin : g_bad_bits
      $error("exc_dispatch: state bit position out of range");
   end

   kind_vec_t        sel;
   logic             take, err;
   logic [NFLAG-1:0] pend_next;
   logic [XLEN-1:0]  vec, srr0, srr1, msr_new;

   exc_tier_sel #(.NFLAG(NFLAG)) u_tier (
      .pend(pend_i), .ext_en(msr_i[BIT_EE]), .sel(sel),
      .take(take), .err(err), .pend_next(pend_next));

   exc_ctx_save #(
      .XLEN(XLEN), .SAVE_MASK(SAVE_MASK), .CLR_MASK(CLR_MASK),
      .BIT_LE(BIT_LE), .BIT_ILE(BIT_ILE), .BIT_ISTAG(BIT_ISTAG)
   ) u_ctx (
      .sel(sel), .take(take), .pc_i(pc_i), .npc_i(npc_i), .msr_i(msr_i),
      .srr1_i(srr1_i), .srr0(srr0), .srr1(srr1), .msr_new(msr_new));

   always_comb begin
      vec = '0;
      if (take)
         for (int unsigned k = 0; k < N_KNOWN; k++)
            if (sel[k]) vec = vec | XLEN'(entry_of(k));
   end

   if (REG_OUT) begin : g_reg
      logic             done_q, taken_q, err_q;
      logic [XLEN-1:0]  vec_q, srr0_q, srr1_q, msr_q;
      logic [NFLAG-1:0] pend_q, snap_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            done_q  <= 1'b0;
            taken_q <= 1'b0;
            err_q   <= 1'b0;
            vec_q   <= '0;
            srr0_q  <= '0;
            srr1_q  <= '0;
            msr_q   <= '0;
            pend_q  <= '0;
            snap_q  <= '0;
         end else begin
            done_q  <= eval_i;
            taken_q <= eval_i & take;
            err_q   <= eval_i & err;
            if (eval_i) begin
               vec_q  <= vec;
               srr0_q <= srr0;
               srr1_q <= srr1;
               msr_q  <= msr_new;
               pend_q <= pend_next;
               snap_q <= pend_i;
            end
         end
      end

      assign done_o  = done_q;
      assign taken_o = taken_q;
      assign err_o   = err_q;
      assign vec_o   = vec_q;
      assign srr0_o  = srr0_q;
      assign srr1_o  = srr1_q;
      assign msr_o   = msr_q;
      assign pend_o  = pend_q;

      // R8: a result appears only one cycle after an evaluation request
      a_r8_done_follows_eval: assert property (@(posedge clk) disable iff (!rst_n)
         done_o |-> $past(eval_i));
      // R8: taken and error flags qualified by the completion pulse
      a_r8_flags_need_done: assert property (@(posedge clk) disable iff (!rst_n)
         (taken_o | err_o) |-> done_o);
      // R9: error never coincides with a dispatch
      a_r9_err_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
         err_o |-> !taken_o);
      // R7: a taken exception removes exactly one pending flag
      a_r7_one_cleared: assert property (@(posedge clk) disable iff (!rst_n)
         taken_o |-> ($countones(snap_q & ~pend_o) == 1 && (pend_o & ~snap_q) == '0));
      // R4: external enable is low after a dispatch when the clear mask covers it
      a_r4_ee_dropped: assert property (@(posedge clk) disable iff (!rst_n)
         (taken_o && CLR_MASK[BIT_EE]) |-> !msr_o[BIT_EE]);
      // R1: entry addresses are 256-byte aligned and non-zero when taken
      a_r1_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
         taken_o |-> (vec_o[7:0] == 8'h00 && vec_o != '0));
   end else begin : g_comb
      assign done_o  = eval_i;
      assign taken_o = eval_i & take;
      assign err_o   = eval_i & err;
      assign vec_o   = vec;
      assign srr0_o  = srr0;
      assign srr1_o  = srr1;
      assign msr_o   = msr_new;
      assign pend_o  = pend_next;

      // R9: error never coincides with a dispatch
      a_r9_err_not_taken_c: assert property (@(posedge clk) disable iff (!rst_n)
         err_o |-> !taken_o);
   end
endmodule

// File: tb/sim_exc_dispatch.sv
module sim_exc_dispatch;
   localparam int NF = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          eval_i = 1'b0;
   logic [NF-1:0] pend_i = '0;
   logic [31:0]   pc_i = '0, npc_i = '0, msr_i = '0, srr1_i = '0;
   logic          done_o, taken_o, err_o;
   logic [31:0]   vec_o, srr0_o, srr1_o, msr_o;
   logic [NF-1:0] pend_o;

   int n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   exc_dispatch u0 (
      .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .pend_i(pend_i),
      .pc_i(pc_i), .npc_i(npc_i), .msr_i(msr_i), .srr1_i(srr1_i),
      .done_o(done_o), .taken_o(taken_o), .err_o(err_o), .vec_o(vec_o),
      .srr0_o(srr0_o), .srr1_o(srr1_o), .msr_o(msr_o), .pend_o(pend_o));

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // expected outcome from the requirements
   function automatic void predict(
      input logic [NF-1:0] p, input logic [31:0] pc, npc, msr, s1,
      output logic tk, output logic er, output logic [31:0] v, s0, s1o, m,
      output logic [NF-1:0] po);
      int win;
      int sync_order[7] = '{0, 1, 2, 3, 4, 5, 6};
      logic [31:0] keep;
      win = -1;
      tk = 0; er = 0; v = 0; s0 = 0; s1o = 0; m = msr; po = p;
      foreach (sync_order[k]) if (win < 0 && p[sync_order[k]]) win = sync_order[k];
      if (win < 0 && msr[15]) begin                       // R6
         if (p[7]) win = 7; else if (p[8]) win = 8; else if (p[9]) win = 9;
         else if (p != 0) er = 1;                         // R9
      end
      if (win == 4) begin                                 // R5
         po[4] = 0; po[5] = 0;
      end else if (win >= 0) begin
         tk = 1;
         po[win] = 0;                                     // R7
         case (win)
            0: v = 32'h400; 1: v = 32'h700; 2: v = 32'hC00; 3: v = 32'h800;
            5: v = 32'h300; 6: v = 32'h600; 7: v = 32'h500; 8: v = 32'hF00;
            default: v = 32'h900;
         endcase
         s0 = (win == 0 || win == 2 || win >= 7) ? npc : pc;   // R2
         keep = msr & 32'h87C0FFFF;                            // R3
         s1o = (win == 1) ? (s1 | keep) : keep;
         if (win == 0) s1o[30] = 1'b1;
         m = msr; m[0] = msr[16];                              // R4
         m = m & ~32'h0004EF36;
      end
   endfunction

   task automatic run_one(input logic [NF-1:0] p, input logic [31:0] msr);
      logic tk, er;
      logic [31:0] v, s0, s1o, m;
      logic [NF-1:0] po;
      pend_i = p; msr_i = msr;
      pc_i = $urandom & 32'hFFFF_FFFC; npc_i = pc_i + 4; srr1_i = $urandom;
      predict(p, pc_i, npc_i, msr_i, srr1_i, tk, er, v, s0, s1o, m, po);
      eval_i = 1'b1;
      @(negedge clk);
      eval_i = 1'b0;
      chk(done_o == 1'b1, "R8 done", 32'(done_o), 32'd1);
      chk(taken_o == tk, "R1/R5/R6 taken", 32'(taken_o), 32'(tk));
      chk(err_o == er, "R9 err", 32'(err_o), 32'(er));
      chk(pend_o == po, "R7 pend", 32'(pend_o), 32'(po));
      chk(msr_o == m, "R4 msr", msr_o, m);
      if (tk) begin
         chk(vec_o == v, "R1 vector", vec_o, v);
         chk(srr0_o == s0, "R2 srr0", srr0_o, s0);
         chk(srr1_o == s1o, "R3 srr1", srr1_o, s1o);
      end
      if ($urandom % 3 == 0) begin
         @(negedge clk);
         chk(done_o == 1'b0 && taken_o == 1'b0, "R8 single pulse",
             32'({done_o, taken_o}), 32'd0);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R10 reset state
      chk({done_o, taken_o, err_o} == 3'b0 && vec_o == 0 && msr_o == 0 && pend_o == 0,
          "R10 reset", vec_o | msr_o, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed: each known flag alone, enable set
      for (int b = 0; b < 10; b++) run_one(NF'(1 << b), 32'h0001_8001);
      // R1 priority: program beats FPU and alignment
      run_one(NF'(12'b0000_0100_1010), 32'h0000_8000);
      // R5 memcheck with data-storage pending
      run_one(NF'(12'b0000_0011_0000), 32'hFFFF_FFFF);
      // R6 async masked when enable low
      run_one(NF'(12'b0011_1000_0000), 32'h0000_0000);
      // R6 sync flag hides async tier
      run_one(NF'(12'b0010_1000_0000 | 12'b100), 32'h0000_8000);
      // R9 unknown async bits only
      run_one(NF'(12'b1100_0000_0000), 32'h0000_8000);
      run_one(NF'(12'b1100_0000_0000), 32'h0000_0000);
      // constrained random
      for (int t = 0; t < 400; t++) begin
         logic [NF-1:0] p;
         logic [31:0] m;
         case ($urandom % 4)
            0: p = NF'(1 << ($urandom % NF));
            1: p = NF'($urandom);
            2: p = NF'($urandom) & 12'hF80;
            default: p = NF'($urandom) | 12'h030;
         endcase
         m = $urandom;
         run_one(p, m);
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule